// File: doc/BRIEF.md
# Tagged Parallel Sample Output Port

This block collects processed receive samples from several channels and sends them out over one shared 16-bit parallel bus. Each channel delivers a group made of an in-phase word, a quadrature word and a gain word. The block stages each group in a small per-channel buffer and picks the next channel in round-robin order. It then places the words of that group on the bus one after another. Every word carries a channel tag and two flags: one marks in-phase data, the other marks a gain word.

A receiver takes words from the port with a request/acknowledge handshake. A word moves only on a rising edge of the port clock, and only when request and acknowledge are both high. The port clock can be produced by the block itself as a divided copy of the core clock (master), or it can be supplied by the receiver and resynchronised (slave). A sample that arrives while its channel's buffer is full is discarded, and a sticky flag records the loss.

Top module: `tpo_port`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `preq_o` is low and every `ovf_o` bit is 0. Reset also empties the buffers, so no word from before reset is sent afterwards.
- R2: The flags follow the word type. An in-phase word has `piq_o`=1 and `pgain_o`=0. A quadrature word has both flags at 0. A gain word has `piq_o`=0 and `pgain_o`=1. `pch_o` carries the source channel index in binary, in the range 0 to NCH-1.
- R3: A word is transferred only at a rising edge of the port clock at which `preq_o` and `pack_i` are both high. Acknowledge alone, without such an edge, transfers nothing.
- R4: While `preq_o` is high and no transfer takes place, `preq_o`, `pdata_o`, `pch_o`, `piq_o` and `pgain_o` keep their values.
- R5: Within a channel's group the order is fixed: in-phase first, then quadrature, then the gain word. The gain word is sent only if `gain_en_i` for that channel was high when the group was selected.
- R6: Channels that hold data are served round-robin. After reset the search starts at channel 0. After channel c has been served, the search starts at channel c+1 (modulo NCH). A group is never interleaved with words from another channel.
- R7: Each channel buffers up to DEPTH groups, plus one group held for output. A sample that arrives while the buffer is full is dropped and sets that channel's `ovf_o` bit. Accepted samples are never lost or duplicated.
- R8: In master mode (`master_i`=1), `pclk_o` is a square wave with a period of 2*DIV core-clock cycles. Its rising edges are the transfer edges.
- R9: In slave mode (`master_i`=0), `pclk_o` stays low. Transfer edges are the rising edges of `pclk_i` after a two-stage synchroniser.
- R10: An `ovf_o` bit, once set, stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| master_i | input | 1 | 1: the block drives the port clock; 0: the port clock comes from `pclk_i` |
| pclk_i | input | 1 | Port clock from the receiver (slave mode) |
| pclk_o | output | 1 | Port clock generated by the block (master mode), low in slave mode |
| smp_valid_i | input | NCH | Per-channel strobe: a new I/Q/gain group is present |
| smp_i_i | input | NCH*DW | In-phase words, channel c in bits [c*DW +: DW] |
| smp_q_i | input | NCH*DW | Quadrature words, same packing |
| smp_g_i | input | NCH*DW | Gain words, same packing |
| gain_en_i | input | NCH | Per-channel enable for sending the gain word |
| preq_o | output | 1 | Request: a word is on the bus |
| pack_i | input | 1 | Acknowledge from the receiver |
| pdata_o | output | DW | Output data word |
| pch_o | output | CHW | Channel tag of the word |
| piq_o | output | 1 | 1 when the word is in-phase data |
| pgain_o | output | 1 | 1 when the word is a gain word |
| ovf_o | output | NCH | Sticky per-channel overflow flags |

## Verification
The assertions assume that `master_i` does not change while a group is being sent. They also assume that `pack_i` and `pclk_i` only change in the middle of a clock cycle. The bench changes the mode only after the bus has drained. It drives every input two time units after a rising clock edge. In slave mode it holds `pclk_i` high for six core cycles, so each receiver edge gives exactly one synchronised transfer edge. During the random phase it pushes a sample only when its own count of pending groups for that channel is below DEPTH. Overflow therefore occurs only in the directed test that targets it.

// File: rtl/tpo_pkg.sv
package tpo_pkg;

  // Position of the output sequencer within a channel group.
  typedef enum logic [1:0] {
    K_IDLE = 2'd0,
    K_I    = 2'd1,
    K_Q    = 2'd2,
    K_G    = 2'd3
  } word_kind_e;

endpackage

// File: rtl/tpo_fifo.sv
module tpo_fifo #(
  parameter int W     = 48,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;

  // Storage has no reset so it can map onto RAM.
  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign dout  = mem[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == (AW+1)'(DEPTH));

endmodule

// File: rtl/tpo_clkgen.sv
module tpo_clkgen #(
  parameter int DIV = 2,
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic master_i,
  input  logic pclk_i,
  output logic pclk_o,
  output logic tick_o
);

  logic [CW-1:0] cnt;
  logic [2:0]    sync;
  logic          at_end;

  assign at_end = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      pclk_o <= 1'b0;
      sync   <= '0;
    end else begin
      sync <= {sync[1:0], pclk_i};
      if (!master_i) begin
        cnt    <= '0;
        pclk_o <= 1'b0;
      end else if (at_end) begin
        cnt    <= '0;
        pclk_o <= ~pclk_o;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // Transfer edge: the core-clock edge at which the port clock goes high.
  assign tick_o = master_i ? (at_end && !pclk_o) : (sync[1] && !sync[2]);

endmodule

// File: rtl/tpo_rr_arb.sv
module tpo_rr_arb #(
  parameter int N   = 6,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] last_i,
  output logic          gnt_v_o,
  output logic [IW-1:0] gnt_idx_o
);

  always_comb begin
    int idx;
    gnt_v_o   = 1'b0;
    gnt_idx_o = '0;
    idx       = 0;
    for (int k = 1; k <= N; k++) begin
      idx = (int'(last_i) + k) % N;
      if (!gnt_v_o && req_i[idx]) begin
        gnt_v_o   = 1'b1;
        gnt_idx_o = IW'(idx);
      end
    end
  end

endmodule

// File: rtl/tpo_port.sv
module tpo_port #(
  parameter int NCH   = 6,
  parameter int DW    = 16,
  parameter int DEPTH = 4,
  parameter int DIV   = 2,
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              master_i,
  input  logic              pclk_i,
  output logic              pclk_o,
  input  logic [NCH-1:0]    smp_valid_i,
  input  logic [NCH*DW-1:0] smp_i_i,
  input  logic [NCH*DW-1:0] smp_q_i,
  input  logic [NCH*DW-1:0] smp_g_i,
  input  logic [NCH-1:0]    gain_en_i,
  output logic              preq_o,
  input  logic              pack_i,
  output logic [DW-1:0]     pdata_o,
  output logic [CHW-1:0]    pch_o,
  output logic              piq_o,
  output logic              pgain_o,
  output logic [NCH-1:0]    ovf_o
);
  import tpo_pkg::*;

  localparam int GW = 3 * DW;

  logic [GW-1:0]  head [NCH];
  logic [NCH-1:0] f_empty, f_full, f_pop;
  logic [NCH-1:0] ovf_q;
  logic           port_tick;
  logic           gnt_v;
  logic [CHW-1:0] gnt_idx;
  logic [CHW-1:0] last_ch;
  logic           grant_fire;
  logic           xfer;
  word_kind_e     kind;
  logic [DW-1:0]  g_q, g_g;
  logic           g_gen;
  logic [GW-1:0]  sel;

  tpo_clkgen #(.DIV(DIV)) u_clkgen (
    .clk      (clk),
    .rst      (rst),
    .master_i (master_i),
    .pclk_i   (pclk_i),
    .pclk_o   (pclk_o),
    .tick_o   (port_tick)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tpo_fifo #(.W(GW), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst   (rst),
      .push  (smp_valid_i[c] & ~f_full[c]),
      .din   ({smp_g_i[c*DW +: DW], smp_q_i[c*DW +: DW], smp_i_i[c*DW +: DW]}),
      .pop   (f_pop[c]),
      .dout  (head[c]),
      .empty (f_empty[c]),
      .full  (f_full[c])
    );
    assign f_pop[c] = grant_fire && (gnt_idx == CHW'(c));
  end

  always_ff @(posedge clk) begin
    if (rst) ovf_q <= '0;
    else     ovf_q <= ovf_q | (smp_valid_i & f_full);
  end
  assign ovf_o = ovf_q;

  tpo_rr_arb #(.N(NCH)) u_arb (
    .req_i     (~f_empty),
    .last_i    (last_ch),
    .gnt_v_o   (gnt_v),
    .gnt_idx_o (gnt_idx)
  );

  assign grant_fire = (kind == K_IDLE) && gnt_v;
  assign xfer       = port_tick && preq_o && pack_i;
  assign sel        = head[gnt_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      kind    <= K_IDLE;
      preq_o  <= 1'b0;
      pdata_o <= '0;
      pch_o   <= '0;
      piq_o   <= 1'b0;
      pgain_o <= 1'b0;
      last_ch <= CHW'(NCH - 1);
      g_q     <= '0;
      g_g     <= '0;
      g_gen   <= 1'b0;
    end else begin
      unique case (kind)
        K_IDLE: if (gnt_v) begin
          kind    <= K_I;
          preq_o  <= 1'b1;
          pdata_o <= sel[DW-1:0];
          g_q     <= sel[2*DW-1:DW];
          g_g     <= sel[GW-1:2*DW];
          g_gen   <= gain_en_i[gnt_idx];
          pch_o   <= gnt_idx;
          last_ch <= gnt_idx;
          piq_o   <= 1'b1;
          pgain_o <= 1'b0;
        end
        K_I: if (xfer) begin
          kind    <= K_Q;
          pdata_o <= g_q;
          piq_o   <= 1'b0;
        end
        K_Q: if (xfer) begin
          if (g_gen) begin
            kind    <= K_G;
            pdata_o <= g_g;
            pgain_o <= 1'b1;
          end else begin
            kind   <= K_IDLE;
            preq_o <= 1'b0;
          end
        end
        K_G: if (xfer) begin
          kind    <= K_IDLE;
          preq_o  <= 1'b0;
          pgain_o <= 1'b0;
        end
        default: kind <= K_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tpo_port_chk.sv
module tpo_port_chk #(
  parameter int NCH = 6,
  parameter int DW  = 16,
  parameter int CHW = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           master_i,
  input logic           pclk_o,
  input logic           port_tick,
  input logic           preq_o,
  input logic           pack_i,
  input logic [DW-1:0]  pdata_o,
  input logic [CHW-1:0] pch_o,
  input logic           piq_o,
  input logic           pgain_o,
  input logic [NCH-1:0] ovf_o
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    $past(rst) |-> (!preq_o && ovf_o == '0));

  assert_flags_excl_R2: assert property (@(posedge clk) disable iff (rst)
    preq_o |-> !(piq_o && pgain_o));

  assert_tag_range_R2: assert property (@(posedge clk) disable iff (rst)
    preq_o |-> ({1'b0, pch_o} < (CHW+1)'(NCH)));

  assert_hold_stable_R4: assert property (@(posedge clk) disable iff (rst)
    (preq_o && !(port_tick && pack_i)) |=>
      (preq_o && $stable(pdata_o) && $stable(pch_o) && $stable(piq_o) && $stable(pgain_o)));

  assert_i_then_q_R5: assert property (@(posedge clk) disable iff (rst)
    (port_tick && pack_i && preq_o && piq_o) |=>
      (preq_o && !piq_o && !pgain_o && $stable(pch_o)));

  assert_group_starts_i_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(preq_o) |-> (piq_o && !pgain_o));

  assert_group_whole_R6: assert property (@(posedge clk) disable iff (rst)
    (preq_o && $past(preq_o)) |-> $stable(pch_o));

  assert_slave_pclk_low_R9: assert property (@(posedge clk) disable iff (rst)
    !master_i |=> !pclk_o);

  assert_no_overflow_clear_R10: assert property (@(posedge clk) disable iff (rst)
    ((ovf_o & $past(ovf_o)) == $past(ovf_o)));

endmodule

bind tpo_port tpo_port_chk #(.NCH(NCH), .DW(DW), .CHW(CHW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .master_i  (master_i),
  .pclk_o    (pclk_o),
  .port_tick (port_tick),
  .preq_o    (preq_o),
  .pack_i    (pack_i),
  .pdata_o   (pdata_o),
  .pch_o     (pch_o),
  .piq_o     (piq_o),
  .pgain_o   (pgain_o),
  .ovf_o     (ovf_o)
);

// File: tb/tpo_port_tb.sv
module tpo_port_tb;
  localparam int NCH = 6, DW = 16, DEPTH = 4, DIV = 2, CHW = 3, EW = DW + 3;

  logic clk = 0, rst = 1, master = 1, pclk_i = 0, pack = 0;
  logic [NCH-1:0] sv = '0, gen = '0;
  logic [NCH*DW-1:0] si = '0, sq = '0, sg = '0;
  logic pclk_o, preq, piq, pgain;
  logic [DW-1:0] pdata;
  logic [CHW-1:0] pch;
  logic [NCH-1:0] ovf;

  always #5 clk = ~clk;

  tpo_port #(.NCH(NCH), .DW(DW), .DEPTH(DEPTH), .DIV(DIV)) u_dut (
    .clk(clk), .rst(rst), .master_i(master), .pclk_i(pclk_i), .pclk_o(pclk_o),
    .smp_valid_i(sv), .smp_i_i(si), .smp_q_i(sq), .smp_g_i(sg), .gain_en_i(gen),
    .preq_o(preq), .pack_i(pack), .pdata_o(pdata), .pch_o(pch), .piq_o(piq),
    .pgain_o(pgain), .ovf_o(ovf)
  );

  int checks = 0, errors = 0, words = 0;
  logic [EW-1:0] expq [NCH][$];
  int outst [NCH];
  int ordq [$];
  logic open_g = 0;
  int open_ch = 0;
  logic mon_on = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Expected entry: {last, iq, gain, data}
  task automatic check_word(int ch, logic iq, logic g, logic [DW-1:0] d);
    logic [EW-1:0] e;
    if (ch >= NCH) begin chk(0, "R2", "tag out of range", ch, NCH - 1); return; end
    if (expq[ch].size() == 0) begin chk(0, "R3", "unexpected transfer on channel", ch, 0); return; end
    e = expq[ch].pop_front();
    chk({iq, g, d} == e[DW+1:0], "R5", "word flags/data", {iq, g, d}, e[DW+1:0]);
    if (open_g) chk(ch == open_ch, "R6", "group split by channel", ch, open_ch);
    open_g  = !e[DW+2];
    open_ch = ch;
    if (e[DW+2]) outst[ch]--;
    if (iq) ordq.push_back(ch);
    words++;
  endtask

  task automatic stage(int c, bit expect_it);
    logic [DW-1:0] di, dq, dg;
    di = DW'($urandom); dq = DW'($urandom); dg = DW'($urandom);
    si[c*DW +: DW] = di; sq[c*DW +: DW] = dq; sg[c*DW +: DW] = dg;
    if (expect_it) begin
      expq[c].push_back({1'b0, 1'b1, 1'b0, di});
      expq[c].push_back({!gen[c], 1'b0, 1'b0, dq});
      if (gen[c]) expq[c].push_back({1'b1, 1'b0, 1'b1, dg});
      outst[c]++;
    end
  endtask

  task automatic push_groups(logic [NCH-1:0] mask, bit expect_it);
    @(posedge clk); #2;
    for (int c = 0; c < NCH; c++) if (mask[c]) stage(c, expect_it);
    sv = mask;
    @(posedge clk); #2;
    sv = '0;
  endtask

  function automatic bit all_empty();
    for (int c = 0; c < NCH; c++) if (expq[c].size() != 0) return 0;
    return 1;
  endfunction

  task automatic wait_drain();
    while (!all_empty()) @(negedge clk);
    repeat (12) @(negedge clk);
    chk(!preq, "R5", "request low after last word", preq, 0);
  endtask

  task automatic check_order(int exp_ord [$]);
    chk(ordq.size() == exp_ord.size(), "R6", "number of groups served", ordq.size(), exp_ord.size());
    foreach (exp_ord[k])
      if (k < ordq.size()) chk(ordq[k] == exp_ord[k], "R6", "round-robin order", ordq[k], exp_ord[k]);
    ordq.delete();
  endtask

  // Monitor for master mode: transfers on the edge where pclk_o rises.
  logic p_pclk = 0, p_req = 0, p_ack = 0, p_iq = 0, p_g = 0, seen_rise = 0;
  logic [DW-1:0] p_d = '0;
  logic [CHW-1:0] p_ch = '0;
  int per_cnt = 0, per_checks = 0;

  always @(negedge clk) begin
    if (mon_on && master) begin
      if (!p_pclk && pclk_o && p_req && p_ack) begin
        check_word(int'(p_ch), p_iq, p_g, p_d);
      end else if (p_req) begin
        chk(preq && pdata == p_d && pch == p_ch && piq == p_iq && pgain == p_g,
            "R4", "held word changed", {preq, pch, piq, pgain, pdata}, {p_req, p_ch, p_iq, p_g, p_d});
      end
      if (!p_pclk && pclk_o) begin
        if (seen_rise && per_checks < 4) begin
          per_checks++;
          chk(per_cnt == 2 * DIV, "R8", "port clock period", per_cnt, 2 * DIV);
        end
        seen_rise = 1;
        per_cnt = 0;
      end
      per_cnt++;
    end else begin
      seen_rise = 0;
    end
    p_pclk = pclk_o; p_req = preq; p_ack = pack; p_iq = piq; p_g = pgain; p_d = pdata; p_ch = pch;
  end

  task automatic slave_xfer();
    logic [DW-1:0] d; logic [CHW-1:0] ch; logic iq, g;
    while (!preq) @(negedge clk);
    d = pdata; ch = pch; iq = piq; g = pgain;
    @(posedge clk); #2;
    pack = 1; pclk_i = 1;
    repeat (6) @(posedge clk);
    #2; pack = 0; pclk_i = 0;
    chk(pclk_o == 0, "R9", "pclk_o low in slave mode", pclk_o, 0);
    check_word(int'(ch), iq, g, d);
    repeat (3) @(posedge clk);
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (3) @(posedge clk);
    #2 rst = 0;
    open_g = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "all", "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [NCH-1:0] mask;
    void'($urandom(32'd20240));
    for (int c = 0; c < NCH; c++) outst[c] = 0;
    do_reset();
    @(negedge clk);
    chk(!preq, "R1", "request after reset", preq, 0);
    chk(ovf == '0, "R1", "overflow flags after reset", ovf, 0);
    mon_on = 1;

    // Round-robin from reset, then wrap-around of the search pointer
    gen = 6'b101010; pack = 0;
    push_groups(6'h3F, 1);
    @(posedge clk); #2 pack = 1;
    wait_drain();
    check_order('{0, 1, 2, 3, 4, 5});
    push_groups(6'b010010, 1);
    wait_drain();
    check_order('{1, 4});
    push_groups(6'b110001, 1);
    wait_drain();
    check_order('{5, 0, 4});

    // Overflow on channel 3 with the receiver stalled
    @(posedge clk); #2 pack = 0; gen = '0;
    for (int k = 0; k <= DEPTH; k++) begin
      push_groups(6'b001000, 1);
      repeat (2) @(posedge clk);
    end
    @(negedge clk);
    chk(ovf == '0, "R7", "no overflow at full capacity", ovf, 0);
    chk(preq, "R3", "word waits without acknowledge", preq, 1);
    push_groups(6'b001000, 0);
    repeat (2) @(negedge clk);
    chk(ovf == 6'b001000, "R7", "overflow flag on extra sample", ovf, 6'b001000);
    @(posedge clk); #2 pack = 1;
    wait_drain();
    repeat (20) @(negedge clk);
    chk(ovf == 6'b001000, "R10", "overflow flag stays set", ovf, 6'b001000);
    ordq.delete();

    // Random traffic with random acknowledge
    @(posedge clk); #2 gen = NCH'($urandom);
    for (int cyc = 0; cyc < 3000; cyc++) begin
      @(posedge clk); #2;
      sv = '0;
      pack = ($urandom % 4) != 0;
      mask = '0;
      for (int c = 0; c < NCH; c++)
        if (($urandom % 8) == 0 && outst[c] < DEPTH) mask[c] = 1'b1;
      for (int c = 0; c < NCH; c++) if (mask[c]) stage(c, 1);
      sv = mask;
    end
    @(posedge clk); #2 sv = '0; pack = 1;
    wait_drain();
    for (int c = 0; c < NCH; c++)
      chk(outst[c] == 0, "R7", "all accepted groups delivered", outst[c], 0);
    chk(words > 100, "R7", "random traffic produced words", words, 101);
    ordq.delete();

    // Slave mode: receiver-driven port clock
    @(posedge clk); #2 master = 0; pack = 0; gen = NCH'($urandom);
    push_groups(6'h15, 1);
    push_groups(6'h2A, 1);
    while (!preq) @(negedge clk);
    begin
      logic [DW-1:0] hd; logic [CHW-1:0] hc;
      hd = pdata; hc = pch;
      @(posedge clk); #2 pack = 1;
      repeat (20) @(posedge clk);
      #2 pack = 0;
      @(negedge clk);
      chk(preq && pdata == hd && pch == hc, "R9", "no transfer without pclk_i edge", {pch, pdata}, {hc, hd});
    end
    while (!all_empty()) slave_xfer();
    chk(!preq, "R9", "request low after slave drain", preq, 0);
    ordq.delete();

    // Reset clears flags and request
    @(posedge clk); #2 master = 1;
    do_reset();
    @(negedge clk);
    chk(ovf == '0, "R1", "overflow cleared by reset", ovf, 0);
    chk(!preq, "R1", "request low after second reset", preq, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule